// File: doc/BRIEF.md
# Paged Register Digital I/O Port Bank

This block is a byte-wide, register-mapped bus slave that controls forty-eight open-drain I/O lines. The lines are grouped into six 8-bit ports. Each port has its own data register. A bit set to 1 turns on the pin's current sink and pulls the line low. A bit cleared to 0 turns the sink off, and an external pull-up then holds the line high. No separate direction register exists: software uses a line as an input by leaving its bit at 0. A read of a port returns the inverse of the synchronized pin level, so a high line reads 0.

A combined control register carries two fields. The upper two bits are a page number. The lower six bits are one write-lock per port. The page number chooses which of three banks of auxiliary bytes appears in a three-byte window above the control register. Page 1 shows the polarity bytes, page 2 the enable bytes and page 3 the interrupt-identification bytes. Page 0 leaves the window empty. The bank that decodes edge events and acts on these bytes lies outside this block. A read-only summary byte reports which identification bytes are non-zero. Pin levels pass through a two-flop synchronizer before they are read. Read data is registered.

Top module: `dio_paged_bank`

## Requirements
- R1: After synchronous reset, every pin sink output is 0 (released), the control byte reads 0x00, every auxiliary byte is 0x00 and the summary byte at 0x06 reads 0x00.
- R2: A write to offset k (0..5) of an unlocked port loads the byte into that port's data register. The sink outputs pin_sink_o[8k+7:8k] take the new value on the clock edge that accepts the write. A bit at 1 sinks its pin.
- R3: A read of offset k (0..5) returns the bitwise inverse of pin_level_i[8k+7:8k] after two synchronizer flops. A pin change that occurs one cycle before a read strobe is not yet visible to that read.
- R4: Offset 0x07 is the control byte. Bits 7:6 hold the page number, and bit k of bits 5:0 locks port k. The byte reads back exactly as written.
- R5: A write to a port whose lock bit is 1 leaves that port's sink outputs unchanged. Reads of that port and writes to unlocked ports are not affected.
- R6: Offsets 0x08..0x0A address byte 0..2 of the bank chosen by the page number: 1 = polarity, 2 = enable, 3 = interrupt-identification. The three banks are stored separately.
- R7: With page 0, reads of 0x08..0x0A return 0x00 and writes there change no stored byte. Reads of 0x0B..0x0F always return 0x00, and writes there have no effect.
- R8: Offset 0x06 is read-only. Bit j (j = 0..2) is 1 when interrupt-identification byte j is non-zero, and bits 7:3 read 0. Writes to 0x06 are ignored.
- R9: The port data registers at 0x00..0x05 are reachable for read and write whatever page is selected.
- R10: bus_rdata updates on the clock edge that samples bus_rd. It holds its value in every cycle in which bus_rd is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_addr | input | 4 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| pin_level_i | input | 48 | Raw pin levels, bit 8k+b is port k line b |
| pin_sink_o | output | 48 | 1 = sink the pin low, 0 = released |

## Verification
The hardest situation to reach from the ports is a paging conflict. It arises when a window write lands on the wrong bank, or when a write under page 0 or under a locked port disturbs stored state that only another page or a later read can reveal. To expose this, the stimulus fills all three banks with distinct bytes. It then issues window writes under page 0 and port writes under locks, and walks every page again to compare each byte. A long random mix of writes to all sixteen offsets, reads, and changes to the external pin level follows. Every read is compared with a bench-side register model, so cross-bank corruption shows up even when it is many operations old. One directed read is issued right after a pin change, which pins down the synchronizer latency.

// File: rtl/dio_bank_pkg.sv
package dio_bank_pkg;
  localparam int PAGE_W    = 2;
  localparam int NUM_PAGES = 1 << PAGE_W;

  typedef enum logic [PAGE_W-1:0] {
    PAGE_PLAIN = 2'd0,
    PAGE_POL   = 2'd1,
    PAGE_ENA   = 2'd2,
    PAGE_IRQID = 2'd3
  } page_e;
endpackage

// File: rtl/dio_sync.sv
module dio_sync #(
  parameter int W      = 48,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] stage_q [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
    end else begin
      stage_q[0] <= din;
      for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
    end
  end

  assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/dio_port_bank.sv
module dio_port_bank #(
  parameter int NUM_PORTS = 6,
  parameter int PORT_W    = 8,
  parameter int ADDR_W    = 4
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        wr_en,
  input  logic [ADDR_W-1:0]           addr,
  input  logic [PORT_W-1:0]           wdata,
  input  logic [NUM_PORTS-1:0]        lock,
  output logic [NUM_PORTS*PORT_W-1:0] sink_o
);
  for (genvar k = 0; k < NUM_PORTS; k++) begin : g_port
    localparam logic [ADDR_W-1:0] PORT_ADDR = ADDR_W'(k);
    logic [PORT_W-1:0] data_q;
    logic              take;

    assign take = wr_en && (addr == PORT_ADDR) && !lock[k];

    always_ff @(posedge clk) begin
      if (rst)       data_q <= '0;
      else if (take) data_q <= wdata;
    end

    assign sink_o[k*PORT_W +: PORT_W] = data_q;

    // R2: an accepted write appears on the sink outputs one edge later
    p_port_write_r2: assert property (@(posedge clk) disable iff (rst)
      (wr_en && addr == PORT_ADDR && !lock[k]) |=> (sink_o[k*PORT_W +: PORT_W] == $past(wdata)));

    // R5: a write to a locked port leaves its outputs untouched
    p_locked_hold_r5: assert property (@(posedge clk) disable iff (rst)
      (wr_en && addr == PORT_ADDR && lock[k]) |=> $stable(sink_o[k*PORT_W +: PORT_W]));
  end
endmodule

// File: rtl/dio_page_regs.sv
module dio_page_regs
  import dio_bank_pkg::*;
#(
  parameter int NUM_PORTS = 6,
  parameter int PORT_W    = 8,
  parameter int WIN_BYTES = 3,
  parameter int ADDR_W    = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_en,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [PORT_W-1:0]    wdata,
  output logic [PAGE_W-1:0]    page_o,
  output logic [NUM_PORTS-1:0] lock_o,
  output logic [PORT_W-1:0]    win_rdata_o,
  output logic [WIN_BYTES-1:0] pend_o
);
  localparam int NUM_AUX  = NUM_PAGES - 1;
  localparam int NUM_TERM = NUM_AUX * WIN_BYTES;
  localparam int WIN_BASE = NUM_PORTS + 2;
  localparam logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(NUM_PORTS + 1);

  logic [PAGE_W-1:0]        page_q;
  logic [NUM_PORTS-1:0]     lock_q;
  logic [NUM_TERM*PORT_W-1:0] rd_terms;

  always_ff @(posedge clk) begin
    if (rst) begin
      page_q <= '0;
      lock_q <= '0;
    end else if (wr_en && addr == CTRL_ADDR) begin
      page_q <= wdata[PORT_W-1 -: PAGE_W];
      lock_q <= wdata[NUM_PORTS-1:0];
    end
  end

  for (genvar p = 1; p < NUM_PAGES; p++) begin : g_page
    localparam logic [PAGE_W-1:0] PG = PAGE_W'(p);
    for (genvar j = 0; j < WIN_BYTES; j++) begin : g_byte
      localparam logic [ADDR_W-1:0] BYTE_ADDR = ADDR_W'(WIN_BASE + j);
      localparam int IDX = (p - 1) * WIN_BYTES + j;
      logic [PORT_W-1:0] aux_q;
      logic              sel;

      assign sel = (page_q == PG) && (addr == BYTE_ADDR);

      always_ff @(posedge clk) begin
        if (rst)               aux_q <= '0;
        else if (wr_en && sel) aux_q <= wdata;
      end

      assign rd_terms[IDX*PORT_W +: PORT_W] = sel ? aux_q : '0;

      if (PG == PAGE_IRQID) begin : g_pend
        assign pend_o[j] = |aux_q;
      end
    end
  end

  always_comb begin
    win_rdata_o = '0;
    for (int t = 0; t < NUM_TERM; t++) win_rdata_o = win_rdata_o | rd_terms[t*PORT_W +: PORT_W];
  end

  assign page_o = page_q;
  assign lock_o = lock_q;

  // R4: the control byte captures page and lock fields as written
  p_ctrl_write_r4: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == CTRL_ADDR) |=>
      (page_o == $past(wdata[PORT_W-1 -: PAGE_W]) && lock_o == $past(wdata[NUM_PORTS-1:0])));
endmodule

// File: rtl/dio_paged_bank.sv
module dio_paged_bank
  import dio_bank_pkg::*;
#(
  parameter int NUM_PORTS   = 6,
  parameter int PORT_W      = 8,
  parameter int WIN_BYTES   = 3,
  parameter int ADDR_W      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        bus_wr,
  input  logic                        bus_rd,
  input  logic [ADDR_W-1:0]           bus_addr,
  input  logic [PORT_W-1:0]           bus_wdata,
  output logic [PORT_W-1:0]           bus_rdata,
  input  logic [NUM_PORTS*PORT_W-1:0] pin_level_i,
  output logic [NUM_PORTS*PORT_W-1:0] pin_sink_o
);
  localparam int NUM_PINS = NUM_PORTS * PORT_W;
  localparam logic [ADDR_W-1:0] PEND_ADDR = ADDR_W'(NUM_PORTS);
  localparam logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(NUM_PORTS + 1);
  localparam logic [ADDR_W-1:0] WIN_ADDR  = ADDR_W'(NUM_PORTS + 2);
  localparam logic [ADDR_W-1:0] END_ADDR  = ADDR_W'(NUM_PORTS + 2 + WIN_BYTES);

  logic [NUM_PINS-1:0]  pin_sync;
  logic [PAGE_W-1:0]    page;
  logic [NUM_PORTS-1:0] lock;
  logic [PORT_W-1:0]    win_rdata;
  logic [WIN_BYTES-1:0] pend;
  logic [PORT_W-1:0]    rd_next;
  logic [PORT_W-1:0]    rdata_q;

  dio_sync #(.W(NUM_PINS), .STAGES(SYNC_STAGES)) i_sync (
    .clk  (clk),
    .rst  (rst),
    .din  (pin_level_i),
    .dout (pin_sync)
  );

  dio_port_bank #(.NUM_PORTS(NUM_PORTS), .PORT_W(PORT_W), .ADDR_W(ADDR_W)) i_ports (
    .clk    (clk),
    .rst    (rst),
    .wr_en  (bus_wr),
    .addr   (bus_addr),
    .wdata  (bus_wdata),
    .lock   (lock),
    .sink_o (pin_sink_o)
  );

  dio_page_regs #(.NUM_PORTS(NUM_PORTS), .PORT_W(PORT_W), .WIN_BYTES(WIN_BYTES),
                  .ADDR_W(ADDR_W)) i_pages (
    .clk         (clk),
    .rst         (rst),
    .wr_en       (bus_wr),
    .addr        (bus_addr),
    .wdata       (bus_wdata),
    .page_o      (page),
    .lock_o      (lock),
    .win_rdata_o (win_rdata),
    .pend_o      (pend)
  );

  always_comb begin
    rd_next = '0;
    for (int k = 0; k < NUM_PORTS; k++) begin
      if (bus_addr == ADDR_W'(k)) rd_next = ~pin_sync[k*PORT_W +: PORT_W];
    end
    if (bus_addr == PEND_ADDR) rd_next = PORT_W'(pend);
    if (bus_addr == CTRL_ADDR) rd_next = PORT_W'({page, lock});
    rd_next = rd_next | win_rdata;
  end

  always_ff @(posedge clk) begin
    if (rst)         rdata_q <= '0;
    else if (bus_rd) rdata_q <= rd_next;
  end

  assign bus_rdata = rdata_q;

  // R1: reset leaves every pin released and read data cleared
  p_reset_clear_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (pin_sink_o == '0 && bus_rdata == '0));

  // R10: read data moves only on a read strobe
  p_rdata_hold_r10: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> $stable(bus_rdata));

  // R7: offsets beyond the window read as zero
  p_unused_zero_r7: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr >= END_ADDR) |=> (bus_rdata == '0));

  // R7: the window is empty on page 0
  p_page0_zero_r7: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && page == PAGE_PLAIN && bus_addr >= WIN_ADDR) |=> (bus_rdata == '0));

  // R8: upper bits of the summary byte read zero
  p_pend_upper_r8: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr == PEND_ADDR) |=> (bus_rdata[PORT_W-1:WIN_BYTES] == '0));
endmodule

// File: tb/test_dio_paged_bank.sv
`timescale 1ns/1ps
module test_dio_paged_bank;
  logic        clk = 1'b0;
  logic        rst;
  logic        bus_wr, bus_rd;
  logic [3:0]  bus_addr;
  logic [7:0]  bus_wdata, bus_rdata;
  logic [47:0] pin_level, pin_sink, ext_lvl;

  int n_vec = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  logic [7:0] m_drv [6];
  logic [5:0] m_lock;
  logic [1:0] m_page;
  logic [7:0] m_aux [3][3];

  always #4 clk = ~clk;

  // open-drain line: low when sunk or pulled low from outside
  assign pin_level = ext_lvl & ~pin_sink;

  dio_paged_bank i_dio_paged_bank (
    .clk         (clk),
    .rst         (rst),
    .bus_wr      (bus_wr),
    .bus_rd      (bus_rd),
    .bus_addr    (bus_addr),
    .bus_wdata   (bus_wdata),
    .bus_rdata   (bus_rdata),
    .pin_level_i (pin_level),
    .pin_sink_o  (pin_sink)
  );

  function automatic logic [7:0] exp_read(input logic [3:0] a);
    if (a < 4'd6) return ~(ext_lvl[a*8 +: 8] & ~m_drv[a]);
    case (a)
      4'd6: return {5'b0, |m_aux[2][2], |m_aux[2][1], |m_aux[2][0]};
      4'd7: return {m_page, m_lock};
      4'd8, 4'd9, 4'd10: return (m_page == 2'd0) ? 8'h00 : m_aux[m_page-1][a-8];
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [47:0] exp_sink();
    logic [47:0] v;
    for (int k = 0; k < 6; k++) v[k*8 +: 8] = m_drv[k];
    return v;
  endfunction

  task automatic check(input string tag, input logic [47:0] got, input logic [47:0] exp);
    n_vec++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic model_reset();
    for (int k = 0; k < 6; k++) m_drv[k] = 8'h00;
    m_lock = '0;
    m_page = '0;
    for (int p = 0; p < 3; p++) for (int j = 0; j < 3; j++) m_aux[p][j] = 8'h00;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    model_reset();
  endtask

  task automatic do_write(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
    if (a < 4'd6) begin
      if (!m_lock[a]) m_drv[a] = d;
    end else if (a == 4'd7) begin
      m_page = d[7:6]; m_lock = d[5:0];
    end else if (a >= 4'd8 && a <= 4'd10 && m_page != 2'd0) begin
      m_aux[m_page-1][a-8] = d;
    end
  endtask

  task automatic do_read(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic check_read(input string tag, input logic [3:0] a);
    logic [7:0] got;
    repeat (3) @(negedge clk);
    do_read(a, got);
    check(tag, {40'h0, got}, {40'h0, exp_read(a)});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_vec++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] v, hold;
    void'($urandom(32'h1d0c_5eed));
    rst = 1'b1; bus_wr = 0; bus_rd = 0; bus_addr = 0; bus_wdata = 0;
    ext_lvl = '1;
    model_reset();
    do_reset();

    // R1 reset state
    check("R1 sink after reset", pin_sink, 48'h0);
    check_read("R1 control byte", 4'd7);
    check_read("R1 summary byte", 4'd6);
    do_write(4'd7, 8'h40); check_read("R1 polarity byte", 4'd8);
    do_write(4'd7, 8'h80); check_read("R1 enable byte", 4'd9);
    do_write(4'd7, 8'hC0); check_read("R1 id byte", 4'd10);
    do_write(4'd7, 8'h00);

    // R2 port writes drive sink outputs
    for (int k = 0; k < 6; k++) do_write(4'(k), 8'(8'h11 * (k + 1)));
    check("R2 sink pattern", pin_sink, exp_sink());

    // R3 inverted read of pins
    for (int k = 0; k < 6; k++) check_read("R3 port read, pull-up high", 4'(k));
    ext_lvl = 48'h0F0F_3C3C_A5A5;
    for (int k = 0; k < 6; k++) check_read("R3 port read, external pattern", 4'(k));

    // R3 synchronizer latency
    do_write(4'd0, 8'h00);
    ext_lvl[7:0] = 8'hFF;
    repeat (4) @(negedge clk);
    ext_lvl[7:0] = 8'h00;
    do_read(4'd0, v);
    check("R3 stale read right after pin change", {40'h0, v}, {40'h0, 8'h00});
    check_read("R3 read after sync settles", 4'd0);
    ext_lvl = '1;

    // R4 control byte
    do_write(4'd7, 8'h45);
    check_read("R4 control readback", 4'd7);

    // R5 locks
    do_write(4'd7, 8'h05);
    do_write(4'd0, 8'hDE); do_write(4'd2, 8'hAD); do_write(4'd1, 8'h3C);
    check("R5 locked ports hold, unlocked changes", pin_sink, exp_sink());
    check_read("R5 locked port still readable", 4'd0);
    do_write(4'd7, 8'h00);

    // R9 ports reachable on every page
    do_write(4'd7, 8'hC0);
    do_write(4'd3, 8'h99);
    check("R9 port write on page 3", pin_sink, exp_sink());
    check_read("R9 port read on page 3", 4'd3);

    // R6 three separate banks
    for (int p = 1; p < 4; p++) begin
      do_write(4'd7, 8'(p << 6));
      for (int j = 0; j < 3; j++) do_write(4'(8 + j), 8'(16 * p + j + 1));
    end
    for (int p = 1; p < 4; p++) begin
      do_write(4'd7, 8'(p << 6));
      for (int j = 0; j < 3; j++) check_read("R6 bank byte readback", 4'(8 + j));
    end

    // R8 summary byte
    check_read("R8 all id bytes set", 4'd6);
    do_write(4'd7, 8'hC0); do_write(4'd9, 8'h00);
    check_read("R8 id byte 1 cleared", 4'd6);
    do_write(4'd6, 8'hFF);
    check_read("R8 write to summary ignored", 4'd6);

    // R7 page 0 window and unused offsets
    do_write(4'd7, 8'h00);
    do_write(4'd8, 8'h55); do_write(4'd10, 8'hAA);
    check_read("R7 page 0 window reads zero", 4'd8);
    for (int a = 11; a < 16; a++) do_write(4'(a), 8'hFF);
    for (int a = 11; a < 16; a++) check_read("R7 unused offset reads zero", 4'(a));
    check("R7 unused writes leave pins", pin_sink, exp_sink());
    for (int p = 1; p < 4; p++) begin
      do_write(4'd7, 8'(p << 6));
      for (int j = 0; j < 3; j++) check_read("R7 banks untouched by page 0 writes", 4'(8 + j));
    end

    // R10 read data holds between strobes
    do_read(4'd7, hold);
    do_write(4'd7, 8'h00);
    do_write(4'd4, 8'h7E);
    repeat (5) @(negedge clk);
    check("R10 rdata holds without strobe", {40'h0, bus_rdata}, {40'h0, hold});

    // random mix
    for (int i = 0; i < 600; i++) begin
      int op;
      op = $urandom_range(0, 9);
      if (op < 4) begin
        do_write(4'($urandom_range(0, 15)), 8'($urandom));
        check("R2 R5 random sink", pin_sink, exp_sink());
      end else if (op < 8) begin
        check_read("R3 R6 R8 random read", 4'($urandom_range(0, 15)));
      end else begin
        ext_lvl = {16'($urandom), 32'($urandom)};
      end
    end

    // R1 reset after activity
    do_reset();
    check("R1 sink after second reset", pin_sink, 48'h0);
    check_read("R1 control after second reset", 4'd7);
    check_read("R1 summary after second reset", 4'd6);
    do_write(4'd7, 8'hC0);
    for (int j = 0; j < 3; j++) check_read("R1 id bytes after second reset", 4'(8 + j));

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule